// File: doc/BRIEF.md
# Grouped Event Selection Matrix

This block sits between the raw event sources of a shared cache and its general-purpose event counters. Raw events are laid out as a two-dimensional array: eight groups (columns), each offering up to 256 event codes (rows). A single 64-bit select register holds one 8-bit code field per group and chooses which code is live in each group. Its top bit is a master enable for all grouped counting.

Each counter lane has two registers. A type register names the group the lane follows, so the lane counts whatever code is currently live in that group. A filter register admits or rejects the event according to an origin tag that travels with each group's events. The tag says which sub-unit raised the event, and which requesting CPU raised it, unless the event carries no ID. Each lane produces a one-cycle increment strobe. Counter storage lives elsewhere.

Software configures the block through a simple address/data port with a combinational read path. Two lanes that name the same group see exactly the same event. Changing the live code of one group therefore reroutes every lane that follows that group at once.

Top module: `esm_matrix`

## Requirements
- R1: After reset every increment strobe is low, and the select, type and filter registers all read back zero. With the select enable clear, grouped counting is off.
- R2: The select register sits at address 0x410 and reads back the full 64-bit value written. Bits [8g+7:8g] hold the live code of group g.
- R3: While select bit 63 is clear, no increment strobe fires, whatever the event and tag inputs are.
- R4: Lane i pulses `inc_o[i]` in the cycle after one in which all of the following hold:
  - the enable is set;
  - the lane's group is valid;
  - the event strobe `ev_i[g*256 + code_g]` is high, where g is the lane's group and code_g is that group's live code;
  - the group's origin tag passes the lane's filter.
  Strobes for non-live codes never count. A register write takes effect from the cycle after the write.
- R5: The type register of lane i is at 0x424 + 16·i. Bits 3:0 name the group, and the register reads back only those bits. Group values 8 to 15 never produce a count. This includes 0xFE, the cycle-counter identifier, whose low nibble is 0xE.
- R6: Lanes that name the same group pulse together for the same event.
- R7: The filter register of lane i is at 0x423 + 16·i, and it stores and reads back only bits 19:17, 2 and 1:0. The origin tag of group g is `tag_i[4g+3:4g]`:
  - bits 3:2 give the sub-unit s, from 0 to 2; the value 3 is never admitted;
  - bit 1 marks an event with no ID;
  - bit 0 selects requester 0 or 1.

  An event passes when filter bit 17+s is set, and also either filter bit 2 is set (for an event with no ID) or filter bit c is set (for requester c). Writing 0x000E0007 passes every valid tag.
- R8: Rewriting one group's field through a read-modify-write of the select register leaves lanes on the other groups counting without a gap.
- R9: Group 7's code field shares bit 63 with the enable. With the enable set, the live code of group 7 is always 0x80 or above.
- R10: Writes to unmapped addresses change no register, and reads of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register address |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Combinational read data for reg_addr_i |
| ev_i | input | 2048 | Raw event strobes, bit g*256+code |
| tag_i | input | 32 | Per-group origin tag, 4 bits per group |
| inc_o | output | 4 | Per-lane increment strobe |

## Verification
A wrong live code, a wrong group index or a stale enable shows as a missing or extra increment strobe exactly one cycle after the event that should, or should not, count. The bench therefore compares the whole strobe vector on every cycle against a model computed from the register values it has written. A corrupted neighbouring field after a select-register rewrite shows up as a lane that falls silent in the very next cycle. A filter bit stored in the wrong place shows as a wrong readback immediately, and as a wrong accept/reject decision during the exhaustive tag-by-filter sweep.

// File: rtl/esm_pkg.sv
package esm_pkg;
  localparam int SEL_ADDR    = 'h410;
  localparam int TYPE_BASE   = 'h424;
  localparam int FLT_BASE    = 'h423;
  localparam int LANE_STRIDE = 16;
  localparam int TYPE_W      = 4;
  localparam int FLT_W       = 6;

  // origin tag carried alongside each group's events
  typedef struct packed {
    logic [1:0] sub;
    logic       no_id;
    logic       cpu;
  } origin_t;

  localparam int TAG_W = $bits(origin_t);

  // compact filter: {sub_en[2:0], no_id_en, cpu_en[1:0]}
  function automatic logic origin_pass(origin_t t, logic [FLT_W-1:0] f);
    logic sub_ok, src_ok;
    case (t.sub)
      2'd0:    sub_ok = f[3];
      2'd1:    sub_ok = f[4];
      2'd2:    sub_ok = f[5];
      default: sub_ok = 1'b0;
    endcase
    src_ok = t.no_id ? f[2] : (t.cpu ? f[1] : f[0]);
    return sub_ok & src_ok;
  endfunction
endpackage

// File: rtl/esm_sel_regs.sv
module esm_sel_regs #(
  parameter int N_GROUPS = 8,
  parameter int CODE_W   = 8,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              en_o,
  output logic [CODE_W-1:0] code_o [N_GROUPS]
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(esm_pkg::SEL_ADDR);

  logic [DATA_W-1:0] sel_q;
  logic              hit;

  assign hit = (addr_i == MY_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           sel_q <= '0;
    else if (we_i && hit)  sel_q <= wdata_i;
  end

  assign en_o    = sel_q[DATA_W-1];
  assign rdata_o = hit ? sel_q : '0;

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_code
    assign code_o[g] = sel_q[g*CODE_W +: CODE_W];
  end

  // R10: other addresses never disturb the select register
  a_r10_sel_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(we_i) && $past(addr_i) != MY_ADDR |-> $stable(sel_q));
endmodule

// File: rtl/esm_group_mux.sv
module esm_group_mux #(
  parameter int CODE_W = 8
) (
  input  logic [(1<<CODE_W)-1:0] ev_i,
  input  logic [CODE_W-1:0]      code_i,
  input  logic                   en_i,
  output logic                   hit_o
);
  assign hit_o = en_i & ev_i[code_i];
endmodule

// File: rtl/esm_ctr_lane.sv
module esm_ctr_lane
  import esm_pkg::*;
#(
  parameter int IDX      = 0,
  parameter int N_GROUPS = 8,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TYPE_W-1:0] type_wd_i,
  input  logic [FLT_W-1:0]  flt_wd_i,
  input  logic              grp_hit_i [N_GROUPS],
  input  origin_t           grp_tag_i [N_GROUPS],
  output logic              inc_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int GW = (N_GROUPS > 1) ? $clog2(N_GROUPS) : 1;
  localparam logic [ADDR_W-1:0] TYPE_ADDR = ADDR_W'(TYPE_BASE + LANE_STRIDE*IDX);
  localparam logic [ADDR_W-1:0] FLT_ADDR  = ADDR_W'(FLT_BASE + LANE_STRIDE*IDX);

  logic [TYPE_W-1:0] type_q;
  logic [FLT_W-1:0]  flt_q;
  logic              inc_q;
  logic              grp_ok;
  logic [GW-1:0]     gidx;
  logic              fire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      type_q <= '0;
      flt_q  <= '0;
    end else if (we_i) begin
      if (addr_i == TYPE_ADDR) type_q <= type_wd_i;
      if (addr_i == FLT_ADDR)  flt_q  <= flt_wd_i;
    end
  end

  assign grp_ok = (32'(type_q) < 32'(N_GROUPS));
  assign gidx   = type_q[GW-1:0];
  assign fire   = grp_ok && grp_hit_i[gidx] && origin_pass(grp_tag_i[gidx], flt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inc_q <= 1'b0;
    else         inc_q <= fire;
  end

  assign inc_o = inc_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == TYPE_ADDR) rdata_o = DATA_W'(type_q);
    if (addr_i == FLT_ADDR)  rdata_o = DATA_W'({flt_q[5:3], 14'b0, flt_q[2:0]});
  end

  // R5: an out-of-range group never yields a count
  a_r5_bad_group_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(32'(type_q) >= 32'(N_GROUPS)) |-> !inc_q);
  // R7: a closed filter admits nothing
  a_r7_closed_filter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(flt_q == '0) |-> !inc_q);
endmodule

// File: rtl/esm_matrix.sv
module esm_matrix
  import esm_pkg::*;
#(
  parameter int N_GROUPS = 8,
  parameter int CODE_W   = 8,
  parameter int N_CTRS   = 4,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 64
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             reg_we_i,
  input  logic [ADDR_W-1:0]                reg_addr_i,
  input  logic [DATA_W-1:0]                reg_wdata_i,
  output logic [DATA_W-1:0]                reg_rdata_o,
  input  logic [N_GROUPS*(1<<CODE_W)-1:0]  ev_i,
  input  logic [N_GROUPS*TAG_W-1:0]        tag_i,
  output logic [N_CTRS-1:0]                inc_o
);
  localparam int N_CODES = 1 << CODE_W;

  logic              sel_en;
  logic [CODE_W-1:0] codes    [N_GROUPS];
  logic              grp_hit  [N_GROUPS];
  origin_t           grp_tag  [N_GROUPS];
  logic [DATA_W-1:0] sel_rdata;
  logic [DATA_W-1:0] lane_rdata [N_CTRS];
  logic [TYPE_W-1:0] type_wd;
  logic [FLT_W-1:0]  flt_wd;

  assign type_wd = reg_wdata_i[TYPE_W-1:0];
  assign flt_wd  = {reg_wdata_i[19:17], reg_wdata_i[2:0]};

  esm_sel_regs #(
    .N_GROUPS(N_GROUPS), .CODE_W(CODE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_sel (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(sel_rdata), .en_o(sel_en), .code_o(codes)
  );

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    esm_group_mux #(.CODE_W(CODE_W)) u_mux (
      .ev_i(ev_i[g*N_CODES +: N_CODES]), .code_i(codes[g]), .en_i(sel_en),
      .hit_o(grp_hit[g])
    );
    assign grp_tag[g] = origin_t'(tag_i[g*TAG_W +: TAG_W]);
  end

  for (genvar i = 0; i < N_CTRS; i++) begin : g_lane
    esm_ctr_lane #(
      .IDX(i), .N_GROUPS(N_GROUPS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_lane (
      .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i),
      .type_wd_i(type_wd), .flt_wd_i(flt_wd),
      .grp_hit_i(grp_hit), .grp_tag_i(grp_tag),
      .inc_o(inc_o[i]), .rdata_o(lane_rdata[i])
    );
  end

  always_comb begin
    reg_rdata_o = sel_rdata;
    for (int i = 0; i < N_CTRS; i++) reg_rdata_o |= lane_rdata[i];
  end

  // R3: master enable clear blocks every lane
  a_r3_gate_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!sel_en) |-> inc_o == '0);
  // R4: a strobe needs some live group hit one cycle earlier
  a_r4_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_o != '0 |-> $past(sel_en));
  // R1: strobes are low in the first cycle after reset
  a_r1_quiet_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> inc_o == '0);
endmodule

// File: tb/esm_matrix_test.sv
module esm_matrix_test;
  localparam int NG = 8, NC = 256, NCTR = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic [NG*NC-1:0] ev = '0;
  logic [NG*4-1:0]  tag = '0;
  logic [NCTR-1:0]  inc;

  int errs = 0, checks = 0;

  logic [63:0] msel = '0;
  logic [3:0]  mtyp [NCTR];
  logic [5:0]  mflt [NCTR];

  always #2 clk = ~clk;

  esm_matrix uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ev_i(ev), .tag_i(tag), .inc_o(inc)
  );

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: run did not finish");
    report();
  end

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic pass_f(input logic [3:0] t, input logic [5:0] f);
    logic [1:0] s = t[3:2];
    logic sub_ok = (s != 2'd3) && f[3 + int'(s)];
    logic src_ok = t[1] ? f[2] : f[int'(t[0])];
    return sub_ok && src_ok;
  endfunction

  function automatic logic [NCTR-1:0] model_inc();
    logic [NCTR-1:0] r = '0;
    for (int i = 0; i < NCTR; i++) begin
      int g = int'(mtyp[i]);
      if (msel[63] && g < NG) begin
        int c = int'(msel[g*8 +: 8]);
        r[i] = ev[g*NC + c] && pass_f(tag[g*4 +: 4], mflt[i]);
      end
    end
    return r;
  endfunction

  task automatic model_write(input logic [11:0] a, input logic [63:0] d);
    if (a == 12'h410) msel = d;
    for (int i = 0; i < NCTR; i++) begin
      if (a == 12'(12'h424 + 16*i)) mtyp[i] = d[3:0];
      if (a == 12'(12'h423 + 16*i)) mflt[i] = {d[19:17], d[2:0]};
    end
  endtask

  // one clock: drive, latch, compare strobes produced from pre-write state
  task automatic cyc(input logic w, input logic [11:0] a, input logic [63:0] d, input string req);
    logic [NCTR-1:0] exp;
    we = w; addr = a; wdata = d;
    exp = model_inc();
    @(posedge clk);
    @(negedge clk);
    chk(64'(inc), 64'(exp), req);
    if (w) model_write(a, d);
    we = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d, input string req);
    cyc(1'b1, a, d, req);
  endtask

  task automatic rd(input logic [11:0] a, input logic [63:0] exp, input string req);
    we = 1'b0; addr = a; #0.5;
    chk(rdata, exp, req);
  endtask

  function automatic logic [63:0] flt_word(input logic [5:0] f);
    return 64'({f[5:3], 14'b0, f[2:0]});
  endfunction

  initial begin
    for (int i = 0; i < NCTR; i++) begin mtyp[i] = '0; mflt[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state, even with every event high
    ev = '1;
    cyc(1'b0, 12'h0, 64'h0, "R1 quiet after reset");
    rd(12'h410, 64'h0, "R1 select resets to zero");
    for (int i = 0; i < NCTR; i++) begin
      rd(12'(12'h424 + 16*i), 64'h0, "R1 type resets to zero");
      rd(12'(12'h423 + 16*i), 64'h0, "R1 filter resets to zero");
    end

    // R7: filter storage and readback
    wr(12'h423, 64'hFFFF_FFFF_FFFF_FFFF, "R7 filter write");
    rd(12'h423, 64'h0000_0000_000E_0007, "R7 filter keeps only its bits");
    for (int i = 0; i < NCTR; i++) wr(12'(12'h423 + 16*i), 64'h000E_0007, "R7 pass-all");

    // R2: select readback
    wr(12'h410, 64'hA5C3_1E7F_0088_4421, "R2 select write");
    rd(12'h410, 64'hA5C3_1E7F_0088_4421, "R2 select readback");

    // R3: enable clear, all events high
    wr(12'h410, 64'h7FFF_FFFF_FFFF_FFFF, "R3 enable clear");
    ev = '1;
    for (int k = 0; k < 4; k++) cyc(1'b0, 12'h0, 64'h0, "R3 nothing counts when disabled");

    // R4/R5/R6 sweep: every group value, live and non-live codes
    for (int g = 0; g < 16; g++) begin
      logic [63:0] s;
      for (int b = 0; b < 8; b++) s[b*8 +: 8] = 8'((g*37 + b*53 + 11) & 8'hFF);
      s[63] = 1'b1;
      wr(12'h410, s, "R2 select load");
      for (int i = 0; i < NCTR; i++)
        wr(12'(12'h424 + 16*i), 64'((g + (i / 2)) & 15), "R6 lane type");
      for (int t = 0; t < 8; t++) begin
        int gg = (g + t) & 7;
        int c  = int'(s[gg*8 +: 8]);
        ev = '0; ev[gg*NC + c] = 1'b1;
        cyc(1'b0, 12'h0, 64'h0, "R4 live code counts");
        ev = '0; ev[gg*NC + ((c + 1) & 255)] = 1'b1;
        cyc(1'b0, 12'h0, 64'h0, "R4 non-live code ignored");
      end
      ev = '1;
      cyc(1'b0, 12'h0, 64'h0, "R5 all events high");
    end

    // R5: cycle-counter identifier in a type register
    wr(12'h424, 64'h0000_00FE, "R5 type write 0xFE");
    rd(12'h424, 64'h0000_000E, "R5 type keeps group nibble");
    ev = '1;
    cyc(1'b0, 12'h0, 64'h0, "R5 invalid group silent");
    chk(64'(inc[0]), 64'h0, "R5 lane0 silent");

    // R7: exhaustive filter x tag on lane 0
    wr(12'h424, 64'h3, "R7 lane0 group 3");
    wr(12'h410, 64'h8000_0000_4400_0000, "R7 select");
    ev = '0; ev[3*NC + 8'h44] = 1'b1;
    for (int f = 0; f < 64; f++) begin
      wr(12'h423, flt_word(6'(f)), "R7 filter load");
      for (int t = 0; t < 16; t++) begin
        tag = '0; tag[3*4 +: 4] = 4'(t);
        cyc(1'b0, 12'h0, 64'h0, "R7 origin filter");
      end
    end
    tag = '0;

    // R8: read-modify-write of one group field
    for (int i = 0; i < NCTR; i++) wr(12'(12'h423 + 16*i), 64'h000E_0007, "R8 pass-all");
    wr(12'h424, 64'h0, "R8 type"); wr(12'h434, 64'h1, "R8 type");
    wr(12'h444, 64'h3, "R8 type"); wr(12'h454, 64'h2, "R8 type");
    wr(12'h410, 64'h8000_0000_3322_1100, "R8 select");
    ev = '0;
    ev[0*NC + 8'h00] = 1'b1; ev[1*NC + 8'h11] = 1'b1;
    ev[2*NC + 8'h22] = 1'b1; ev[3*NC + 8'h33] = 1'b1;
    cyc(1'b0, 12'h0, 64'h0, "R8 all lanes count");
    chk(64'(inc), 64'hF, "R8 all four lanes pulse");
    begin
      logic [63:0] v;
      we = 1'b0; addr = 12'h410; #0.5; v = rdata;
      v[2*8 +: 8] = 8'h5A;
      wr(12'h410, v, "R8 rewrite group 2");
    end
    for (int k = 0; k < 3; k++) cyc(1'b0, 12'h0, 64'h0, "R8 other groups keep counting");
    chk(64'(inc), 64'h7, "R8 only group 2 lane stops");

    // R9: group 7 shares the enable bit
    wr(12'h454, 64'h7, "R9 type group 7");
    wr(12'h410, 64'h0500_0000_0000_0000, "R9 code 0x05 clears enable");
    ev = '0; ev[7*NC + 8'h05] = 1'b1;
    cyc(1'b0, 12'h0, 64'h0, "R9 disabled by code below 0x80");
    wr(12'h410, 64'h8500_0000_0000_0000, "R9 code 0x85");
    ev = '0; ev[7*NC + 8'h85] = 1'b1;
    cyc(1'b0, 12'h0, 64'h0, "R9 group 7 live code 0x85");
    chk(64'(inc), 64'h8, "R9 lane3 counts");

    // R10: unmapped addresses
    wr(12'h411, 64'hFFFF_FFFF_FFFF_FFFF, "R10 unmapped write");
    wr(12'h425, 64'hFFFF_FFFF_FFFF_FFFF, "R10 unmapped write");
    rd(12'h410, 64'h8500_0000_0000_0000, "R10 select unchanged");
    rd(12'h424, 64'h0, "R10 type unchanged");
    rd(12'h411, 64'h0, "R10 unmapped reads zero");
    cyc(1'b0, 12'h0, 64'h0, "R10 counting unchanged");

    report();
  end
endmodule